// File: doc/BRIEF.md
# Signed/Unsigned Decimal Byte Display

This block watches an 8-bit bus and keeps a copy of it in a holding register. The copy changes only in a cycle where the load strobe is high. The held byte is shown in decimal on four seven-segment digits. The `signed_mode` input selects how that byte is read. Low reads it as an unsigned number from 0 to 255. High reads it as a two's-complement number from -128 to +127.

`signed_mode` is not stored. Changing it makes the display reinterpret the byte already held, with no new load. The binary-to-decimal conversion is combinational (shift and add-3 over eight steps), so every held value is fully converted before the next load can arrive.

Loading works like a valid-only stream: `disp_load` is the valid, and there is no back-pressure. The block accepts a byte on every clock edge where `disp_load` is high, including edges that follow one another. A new byte appears on the segments right after the edge that takes it.

Top module: `dec_display`

## Requirements
- R1: After reset the held byte is 0x00, so the display shows a single "0" in the rightmost digit and the other three digits are blank.
- R2: The held byte takes the value of `bus_data` on a rising clock edge where `disp_load` is 1. On an edge where `disp_load` is 0 it keeps its value, whatever `bus_data` is.
- R3: When `signed_mode` is 0, the held byte is shown as an unsigned decimal from 0 to 255 on the three rightmost digits, and the leftmost digit is blank.
- R4: When `signed_mode` is 1 and bit 7 of the held byte is set, the leftmost digit shows the minus sign and the three rightmost digits show 256 minus the byte. So 0xFF shows -1 and 0x80 shows -128.
- R5: When `signed_mode` is 1 and bit 7 of the held byte is clear, the display is the same as in unsigned mode, with a blank leftmost digit.
- R6: Leading zeros of the magnitude are blanked. The rightmost digit is always lit, so a value of zero shows one "0". Zeros that come after a non-zero digit are shown, as in 100.
- R7: Each digit is 7 bits, active high, with bit 0 = segment a through bit 6 = segment g. The digit codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). The minus sign is 40 (segment g only). A blank digit is 00. Digit k sits in `seg_o[7k+6:7k]`, and digit 3 is the leftmost.
- R8: A change of `signed_mode` with no load alters the display combinationally in the same cycle, using the byte already held.
- R9: When a load and a change of `signed_mode` occur in the same cycle, the display after that edge shows the new byte read under the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 8 | Byte offered on the shared bus |
| disp_load | input | 1 | Load strobe (valid); the byte is taken on this edge |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| seg_o | output | 28 | Four 7-bit segment patterns, digit 3 leftmost |

## Verification
A load of a new byte and a flip of the interpretation mode can land in the same cycle. The bench provokes this by driving the load strobe, a new bus byte and the opposite `signed_mode` together before one edge. It then checks that the digits after that edge match the new byte read in the new mode, and match neither the old byte nor the old mode. A separate step flips the mode alone on a held byte of 0xFF. It checks the same cycle for the change between "255" and "-1", which shows the mode path is combinational and the load path is not.

// File: rtl/dec_disp_pkg.sv
package dec_disp_pkg;
  localparam int SEG_W = 7;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'h00;
  localparam logic [SEG_W-1:0] SEG_MINUS = 7'h40;

  // BCD digit to active-high gfedcba pattern
  function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/dd_bin2bcd.sv
module dd_bin2bcd #(
  parameter int DATA_W = 8,
  parameter int BCD_N  = 3
) (
  input  logic [DATA_W-1:0]  bin,
  output logic [BCD_N*4-1:0] bcd
);
  localparam int WORK_W = BCD_N*4 + DATA_W;

  logic [WORK_W-1:0] work;

  // shift-and-add-3, one pass per input bit
  always_comb begin
    work = {{(BCD_N*4){1'b0}}, bin};
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < BCD_N; j++) begin
        if (work[DATA_W+4*j +: 4] >= 4'd5)
          work[DATA_W+4*j +: 4] = work[DATA_W+4*j +: 4] + 4'd3;
      end
      work = work << 1;
    end
  end

  assign bcd = work[DATA_W +: BCD_N*4];

  // R3: every converted digit is a decimal digit
  always_comb begin
    for (int k = 0; k < BCD_N; k++) begin
      a_r3_bcd_digit_range: assert (bcd[4*k +: 4] <= 4'd9);
    end
  end
endmodule

// File: rtl/dd_seg_row.sv
module dd_seg_row
  import dec_disp_pkg::*;
#(
  parameter int BCD_N = 3,
  parameter int NDIG  = BCD_N + 1
) (
  input  logic [BCD_N*4-1:0]  bcd,
  input  logic                neg,
  output logic [NDIG*SEG_W-1:0] seg
);
  logic [BCD_N-1:0] nz;
  logic [BCD_N-1:0] lit;

  genvar k;
  generate
    for (k = 0; k < BCD_N; k++) begin : g_dig
      assign nz[k] = |bcd[4*k +: 4];
      // a digit is lit if it or any digit to its left is non-zero
      if (k == BCD_N-1) begin : g_top
        assign lit[k] = nz[k] | (k == 0);
      end else if (k == 0) begin : g_units
        assign lit[k] = 1'b1;
      end else begin : g_mid
        assign lit[k] = nz[k] | lit[k+1];
      end
      assign seg[k*SEG_W +: SEG_W] = lit[k] ? seg_of(bcd[4*k +: 4]) : SEG_BLANK;
    end
  endgenerate

  // sign position: leftmost digit
  assign seg[BCD_N*SEG_W +: SEG_W] = neg ? SEG_MINUS : SEG_BLANK;
endmodule

// File: rtl/dec_display.sv
module dec_display
  import dec_disp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           bus_data,
  input  logic                        disp_load,
  input  logic                        signed_mode,
  output logic [(((DATA_W*301)/1000)+2)*7-1:0] seg_o
);
  localparam int BCD_N = ((DATA_W*301)/1000) + 1;
  localparam int NDIG  = BCD_N + 1;

  logic [DATA_W-1:0]  held;
  logic               neg;
  logic [DATA_W-1:0]  mag;
  logic [BCD_N*4-1:0] bcd;

  always_ff @(posedge clk) begin
    if (!rst_n)         held <= '0;
    else if (disp_load) held <= bus_data;
  end

  assign neg = signed_mode & held[DATA_W-1];
  // two's-complement magnitude; the most negative value maps onto itself
  assign mag = neg ? (~held + 1'b1) : held;

  dd_bin2bcd #(.DATA_W(DATA_W), .BCD_N(BCD_N)) u_b2b (
    .bin (mag),
    .bcd (bcd)
  );

  dd_seg_row #(.BCD_N(BCD_N), .NDIG(NDIG)) u_row (
    .bcd (bcd),
    .neg (neg),
    .seg (seg_o)
  );

  // R2: capture on strobe, hold otherwise
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    disp_load |=> held == $past(bus_data));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_load |=> $stable(held));
  // R3: unsigned view never uses the leftmost digit
  a_r3_left_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |-> seg_o[NDIG*SEG_W-1 -: SEG_W] == SEG_BLANK);
  // R4: negative signed value carries the minus sign
  a_r4_minus_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (signed_mode && held[DATA_W-1]) |-> seg_o[NDIG*SEG_W-1 -: SEG_W] == SEG_MINUS);
  // R6: units digit is never blank
  a_r6_units_lit: assert property (@(posedge clk) disable iff (!rst_n)
    seg_o[SEG_W-1:0] != SEG_BLANK);
endmodule

// File: tb/dec_display_bench.sv
module dec_display_bench;
  localparam logic [6:0] B  = 7'h00, M  = 7'h40;
  localparam logic [6:0] S0 = 7'h3F, S1 = 7'h06, S2 = 7'h5B, S3 = 7'h4F, S4 = 7'h66;
  localparam logic [6:0] S5 = 7'h6D, S6 = 7'h7D, S7 = 7'h07, S8 = 7'h7F, S9 = 7'h6F;

  typedef struct packed {
    logic        m;
    logic [7:0]  d;
    logic [27:0] e;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, {B, B, B, S0}},    // R6 zero
    '{1'b0, 8'hFF, {B, S2, S5, S5}},  // R3 max
    '{1'b0, 8'h09, {B, B, B, S9}},
    '{1'b0, 8'h0A, {B, B, S1, S0}},
    '{1'b0, 8'h64, {B, S1, S0, S0}},  // R6 inner zeros kept
    '{1'b0, 8'h80, {B, S1, S2, S8}},  // R3
    '{1'b0, 8'h2E, {B, B, S4, S6}},   // R7 codes 4,6
    '{1'b0, 8'hEB, {B, S2, S3, S5}},  // R7 code 3
    '{1'b0, 8'h37, {B, B, S5, S5}},
    '{1'b1, 8'hFF, {M, B, B, S1}},    // R4 -1
    '{1'b1, 8'h80, {M, S1, S2, S8}},  // R4 -128
    '{1'b1, 8'h7F, {B, S1, S2, S7}},  // R5 +127
    '{1'b1, 8'h00, {B, B, B, S0}},    // R5 zero
    '{1'b1, 8'h9C, {M, S1, S0, S0}},  // R4 -100
    '{1'b1, 8'hF6, {M, B, S1, S0}},   // R4 -10
    '{1'b1, 8'h65, {B, S1, S0, S1}},  // R5 101
    '{1'b1, 8'hC9, {M, B, S5, S5}},   // R4 -55
    '{1'b0, 8'hC9, {B, S2, S0, S1}}   // R3 201
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_data = 8'h00;
  logic        disp_load = 1'b0;
  logic        signed_mode = 1'b0;
  logic [27:0] seg_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dec_display u_dec_display (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
    .disp_load(disp_load), .signed_mode(signed_mode), .seg_o(seg_o)
  );

  task automatic check(input string req, input logic [27:0] exp);
    total++;
    if (seg_o !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, seg_o, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at the following negedge
  task automatic load(input logic m, input logic [7:0] d);
    @(negedge clk);
    signed_mode = m;
    bus_data    = d;
    disp_load   = 1'b1;
    @(negedge clk);
    disp_load   = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {B, B, B, S0});

    // R2: bus changes without strobe are ignored
    bus_data = 8'hFF;
    repeat (2) @(negedge clk);
    check("R2", {B, B, B, S0});

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].m, VECS[i].d);
      check(VECS[i].m ? "R4/R5" : "R3", VECS[i].e);
    end

    // R2: held value survives bus activity with strobe low
    load(1'b0, 8'h7B);
    check("R2", {B, S1, S2, S3});
    bus_data = 8'h01;
    repeat (3) @(negedge clk);
    check("R2", {B, S1, S2, S3});

    // R8: mode flip alone reinterprets the held byte in the same cycle
    load(1'b0, 8'hFF);
    check("R8", {B, S2, S5, S5});
    signed_mode = 1'b1;
    #1;
    check("R8", {M, B, B, S1});
    signed_mode = 1'b0;
    #1;
    check("R8", {B, S2, S5, S5});

    // R9: load and mode change in one cycle
    load(1'b1, 8'h80);
    check("R9", {M, S1, S2, S8});
    load(1'b0, 8'h81);
    check("R9", {B, S1, S2, S9});

    // R1: reset clears the held byte
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", {B, B, B, S0});

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule